// File: doc/BRIEF.md
# Dual-Page Two-Wire Management Slave

This block is the management-side slave of an optical link module. It listens on an open-drain two-wire bus and answers two fixed 7-bit device addresses. The first address opens a read-only identification page. The second opens a diagnostics page backed by register storage. Each page holds 256 byte locations. Bus masters use the usual transfers. A write loads an internal byte pointer, and any further bytes in that write are stored from the pointer onward. A repeated start followed by a read streams bytes from the pointer. The pointer advances after every byte moved in either direction.

Inside the diagnostics page, one byte is not storage. It is a live register built from the module's status inputs and one soft-control bit, and it drives the soft laser-disable output. The identification page contents are computed from its byte index and a seed parameter, so the page needs no storage. The block samples SCL and SDA on the system clock. It never stretches the clock, and it pulls SDA low only through its drive-enable output.

Top module: `mgmt_twowire_slave`

## Requirements
- R1: After reset, `sda_oe_o` and `soft_disable_o` are both 0 and the byte pointer is 0.
- R2: Device byte 0xA0/0xA1 (7-bit address 0x50) is acknowledged and selects the identification page. Byte n of that page reads as n XOR 0x5A with the default seed.
- R3: A device byte whose upper seven bits are neither 0x50 nor 0x51 gets no acknowledge. The block then leaves SDA undriven until the next START.
- R4: Device byte 0xA2/0xA3 (7-bit address 0x51) selects the diagnostics page. In a write, the first data byte loads the pointer. Each later byte is stored at the pointer, which then advances. A repeated start followed by a read returns bytes from the pointer onward.
- R5: The byte pointer wraps from 255 to 0 within the page, for both writes and reads.
- R6: Diagnostics bytes 0 to 247, except byte 110, accept writes and read back the written value. This includes both the lower half (0 to 127) and the user half (128 to 247).
- R7: Data bytes written to the identification page, or to diagnostics bytes 248 to 255, are acknowledged and discarded. Diagnostics bytes 248 to 255 read as 0.
- R8: Diagnostics byte 110 reads live as {disable pin, soft disable, 0, rate-select pin, 0, fault, loss of signal, not-ready}, from bit 7 down to bit 0.
- R9: Only bit 6 of byte 110 is writable. It sets `soft_disable_o`. Bit 3 (soft rate control) ignores writes and reads 0, and `soft_disable_o` changes only through such a write.
- R10: A STOP returns the block to idle with SDA released. Bytes clocked after a STOP, without a new START, get no acknowledge.
- R11: When the master answers a read byte with NACK, the read ends. The block leaves SDA undriven until the next START.
- R12: `sda_oe_o` changes only while SCL is low, except at a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| tx_dis_pin_i | input | 1 | Level of the hardware transmit-disable pin |
| rate_pin_i | input | 1 | Level of the rate-select pin |
| tx_fault_i | input | 1 | Transmitter fault status |
| rx_los_i | input | 1 | Receiver loss-of-signal status |
| not_ready_i | input | 1 | 1 while monitor data is not yet valid |
| soft_disable_o | output | 1 | Soft laser-disable control written through byte 110 |

## Verification
The bound checker enforces the cycle-level bus rules on every cycle. SDA drive must move only while SCL is low. A detected STOP must release SDA on the next cycle. The soft-disable output may change only in the cycle after a write strobe to byte 110. Reset must clear both outputs. Address decoding, pointer loading and wrap, region-based write permission, the live layout of byte 110 and read termination on NACK all depend on complete bus transactions. Only the bench's directed scenarios show those, by comparing acknowledge bits and returned bytes with independently computed values.

// File: rtl/mgmt_twowire_pkg.sv
package mgmt_twowire_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_DEVACK,
        ST_WBYTE,
        ST_WACK,
        ST_RBYTE,
        ST_RACK
    } link_state_e;

    typedef enum logic {
        PG_IDENT = 1'b0,
        PG_DIAG  = 1'b1
    } page_e;

    function automatic logic [7:0] ident_byte(input logic [7:0] idx, input logic [7:0] seed);
        return idx ^ seed;
    endfunction

endpackage

// File: rtl/mgmt_bus_sampler.sv
module mgmt_bus_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o,
    output logic sda_o
);
    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [LAST:0] scl_sync;
        logic [LAST:0] sda_sync;
        logic          scl_prev;
        logic          sda_prev;
    } smp_t;

    smp_t q, d;

    always_comb begin
        d = q;
        d.scl_sync = {q.scl_sync[LAST-1:0], scl_i};
        d.sda_sync = {q.sda_sync[LAST-1:0], sda_i};
        d.scl_prev = q.scl_sync[LAST];
        d.sda_prev = q.sda_sync[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    // Events are taken between the last sync stage and its delayed copy.
    assign sda_o      = q.sda_sync[LAST];
    assign scl_rise_o = q.scl_sync[LAST] & ~q.scl_prev;
    assign scl_fall_o = ~q.scl_sync[LAST] & q.scl_prev;
    assign start_o    = q.scl_sync[LAST] & q.scl_prev & q.sda_prev & ~q.sda_sync[LAST];
    assign stop_o     = q.scl_sync[LAST] & q.scl_prev & ~q.sda_prev & q.sda_sync[LAST];
endmodule

// File: rtl/mgmt_link_engine.sv
module mgmt_link_engine
    import mgmt_twowire_pkg::*;
#(
    parameter logic [6:0] IDENT_DEV = 7'h50,
    parameter logic [6:0] DIAG_DEV  = 7'h51
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_rise_i,
    input  logic       scl_fall_i,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic       sda_i,
    input  logic [7:0] rd_data_i,
    output logic       page_o,
    output logic [7:0] ptr_o,
    output logic       wr_en_o,
    output logic [7:0] wr_data_o,
    output logic       sda_oe_o
);
    typedef struct packed {
        link_state_e st;
        logic [3:0]  cnt;
        logic [7:0]  sh;
        logic [7:0]  ptr;
        logic        page;
        logic        rd;
        logic        first;
        logic        nack;
        logic        oe;
    } eng_t;

    eng_t q, d;
    logic wr_en;

    always_comb begin
        d     = q;
        wr_en = 1'b0;
        if (start_i) begin
            d.st  = ST_DEVADDR;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else if (stop_i) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else begin
            unique case (q.st)
                ST_DEVADDR: begin
                    if (scl_rise_i) begin
                        d.sh  = {q.sh[6:0], sda_i};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall_i && q.cnt == 4'd8) begin
                        if (q.sh[7:1] == IDENT_DEV || q.sh[7:1] == DIAG_DEV) begin
                            d.page = (q.sh[7:1] == DIAG_DEV);
                            d.rd   = q.sh[0];
                            d.oe   = 1'b1;
                            d.st   = ST_DEVACK;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                ST_DEVACK: begin
                    if (scl_fall_i) begin
                        d.cnt = '0;
                        if (q.rd) begin
                            d.sh  = rd_data_i;
                            d.oe  = ~rd_data_i[7];
                            d.ptr = q.ptr + 8'd1;
                            d.st  = ST_RBYTE;
                        end else begin
                            d.oe    = 1'b0;
                            d.first = 1'b1;
                            d.st    = ST_WBYTE;
                        end
                    end
                end
                ST_WBYTE: begin
                    if (scl_rise_i) begin
                        d.sh  = {q.sh[6:0], sda_i};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall_i && q.cnt == 4'd8) begin
                        if (q.first) begin
                            d.ptr = q.sh;
                        end else begin
                            wr_en = 1'b1;
                            d.ptr = q.ptr + 8'd1;
                        end
                        d.first = 1'b0;
                        d.oe    = 1'b1;
                        d.st    = ST_WACK;
                    end
                end
                ST_WACK: begin
                    if (scl_fall_i) begin
                        d.oe  = 1'b0;
                        d.cnt = '0;
                        d.st  = ST_WBYTE;
                    end
                end
                ST_RBYTE: begin
                    if (scl_fall_i) begin
                        if (q.cnt == 4'd7) begin
                            d.oe = 1'b0;
                            d.st = ST_RACK;
                        end else begin
                            d.cnt = q.cnt + 4'd1;
                            d.sh  = {q.sh[6:0], 1'b0};
                            d.oe  = ~q.sh[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise_i) begin
                        d.nack = sda_i;
                    end else if (scl_fall_i) begin
                        if (q.nack) begin
                            d.st = ST_IDLE;
                        end else begin
                            d.sh  = rd_data_i;
                            d.oe  = ~rd_data_i[7];
                            d.ptr = q.ptr + 8'd1;
                            d.cnt = '0;
                            d.st  = ST_RBYTE;
                        end
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign page_o    = q.page;
    assign ptr_o     = q.ptr;
    assign wr_en_o   = wr_en;
    assign wr_data_o = q.sh;
    assign sda_oe_o  = q.oe;
endmodule

// File: rtl/mgmt_page_store.sv
module mgmt_page_store
    import mgmt_twowire_pkg::*;
#(
    parameter logic [7:0] IDENT_SEED = 8'h5A,
    parameter logic [7:0] LIVE_IDX   = 8'd110,
    parameter logic [7:0] USER_LAST  = 8'd247,
    parameter int         DEPTH      = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       page_i,
    input  logic [7:0] addr_i,
    input  logic       wr_en_i,
    input  logic [7:0] wr_data_i,
    input  logic       tx_dis_pin_i,
    input  logic       rate_pin_i,
    input  logic       tx_fault_i,
    input  logic       rx_los_i,
    input  logic       not_ready_i,
    output logic [7:0] rd_data_o,
    output logic       soft_disable_o
);
    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic                  soft_dis;
    } store_t;

    store_t q, d;
    logic [7:0] live_byte;

    always_comb begin
        d = q;
        if (wr_en_i && page_i == PG_DIAG) begin
            if (addr_i == LIVE_IDX)       d.soft_dis     = wr_data_i[6];
            else if (addr_i <= USER_LAST) d.mem[addr_i]  = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign live_byte = {tx_dis_pin_i, q.soft_dis, 1'b0, rate_pin_i,
                        1'b0, tx_fault_i, rx_los_i, not_ready_i};

    always_comb begin
        if (page_i == PG_IDENT)      rd_data_o = ident_byte(addr_i, IDENT_SEED);
        else if (addr_i == LIVE_IDX) rd_data_o = live_byte;
        else                         rd_data_o = q.mem[addr_i];
    end

    assign soft_disable_o = q.soft_dis;
endmodule

// File: rtl/mgmt_twowire_slave.sv
module mgmt_twowire_slave #(
    parameter logic [6:0] IDENT_DEV   = 7'h50,
    parameter logic [6:0] DIAG_DEV    = 7'h51,
    parameter logic [7:0] IDENT_SEED  = 8'h5A,
    parameter logic [7:0] LIVE_IDX    = 8'd110,
    parameter logic [7:0] USER_LAST   = 8'd247,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe_o,
    input  logic tx_dis_pin_i,
    input  logic rate_pin_i,
    input  logic tx_fault_i,
    input  logic rx_los_i,
    input  logic not_ready_i,
    output logic soft_disable_o
);
    localparam int PTR_W = 8;
    localparam int DEPTH = 1 << PTR_W;

    logic             scl_rise, scl_fall, start_w, stop_w, sda_s;
    logic             page_w, wr_en_w;
    logic [PTR_W-1:0] ptr_w;
    logic [7:0]       wr_data_w, rd_data_w;

    mgmt_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
        .start_o(start_w), .stop_o(stop_w), .sda_o(sda_s)
    );

    mgmt_link_engine #(.IDENT_DEV(IDENT_DEV), .DIAG_DEV(DIAG_DEV)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
        .start_i(start_w), .stop_i(stop_w), .sda_i(sda_s),
        .rd_data_i(rd_data_w), .page_o(page_w), .ptr_o(ptr_w),
        .wr_en_o(wr_en_w), .wr_data_o(wr_data_w), .sda_oe_o(sda_oe_o)
    );

    mgmt_page_store #(
        .IDENT_SEED(IDENT_SEED), .LIVE_IDX(LIVE_IDX),
        .USER_LAST(USER_LAST), .DEPTH(DEPTH)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .page_i(page_w), .addr_i(ptr_w),
        .wr_en_i(wr_en_w), .wr_data_i(wr_data_w),
        .tx_dis_pin_i(tx_dis_pin_i), .rate_pin_i(rate_pin_i),
        .tx_fault_i(tx_fault_i), .rx_los_i(rx_los_i), .not_ready_i(not_ready_i),
        .rd_data_o(rd_data_w), .soft_disable_o(soft_disable_o)
    );
endmodule

// File: rtl/mgmt_twowire_chk.sv
module mgmt_twowire_chk #(
    parameter logic [7:0] LIVE_IDX = 8'd110
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe_o,
    input logic       soft_disable_o,
    input logic       stop_seen,
    input logic       wr_en,
    input logic       wr_page,
    input logic [7:0] wr_addr
);
    // R1: reset leaves both outputs inactive
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!sda_oe_o && !soft_disable_o));

    // R10: a detected STOP releases SDA
    a_r10_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        stop_seen |=> !sda_oe_o);

    // R9: soft disable moves only after a write strobe to the live byte
    a_r9_soft_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(soft_disable_o) |-> $past(wr_en && wr_page && wr_addr == LIVE_IDX));

    // R12: SDA drive changes only with SCL low, apart from a STOP
    a_r12_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe_o) && !$past(stop_seen)) |-> !scl_i);
endmodule

bind mgmt_twowire_slave mgmt_twowire_chk #(.LIVE_IDX(LIVE_IDX)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
    .soft_disable_o(soft_disable_o), .stop_seen(stop_w),
    .wr_en(wr_en_w), .wr_page(page_w), .wr_addr(ptr_w)
);

// File: tb/mgmt_twowire_slave_tb.sv
module mgmt_twowire_slave_tb;
    localparam int Q = 16;
    localparam logic [7:0] SEED = 8'h5A;

    logic clk = 0, rst_n = 0;
    logic scl = 1, sda_m = 1;
    logic tx_dis = 0, rate = 0, fault = 0, los = 0, nrdy = 0;
    logic sda_oe, soft_dis;
    logic sda_line;
    int   n_tests = 0, n_fail = 0;
    bit   done = 0;

    always #2 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    mgmt_twowire_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
        .tx_dis_pin_i(tx_dis), .rate_pin_i(rate), .tx_fault_i(fault),
        .rx_los_i(los), .not_ready_i(nrdy), .soft_disable_o(soft_dis)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R12 monitor: drive may only move with SCL low (STOP excluded: slave is released then)
    int  r12_bad = 0;
    logic oe_prev = 0;
    always @(negedge clk) begin
        if (rst_n && sda_oe != oe_prev && scl) r12_bad++;
        oe_prev = sda_oe;
    end

    task automatic wq(input int n); repeat (n) @(negedge clk); endtask
    task automatic bus_start(); sda_m = 1; scl = 1; wq(Q); sda_m = 0; wq(Q); scl = 0; wq(Q); endtask
    task automatic bus_rstart(); sda_m = 1; wq(Q); scl = 1; wq(Q); sda_m = 0; wq(Q); scl = 0; wq(Q); endtask
    task automatic bus_stop(); sda_m = 0; wq(Q); scl = 1; wq(Q); sda_m = 1; wq(Q); endtask

    task automatic send(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(Q); scl = 1; wq(Q); scl = 0;
        end
        sda_m = 1; wq(Q); scl = 1; wq(Q/2);
        ack = ~sda_line;
        wq(Q/2); scl = 0; wq(2);
    endtask

    task automatic recv(input logic nack, output logic [7:0] b);
        sda_m = 1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q); scl = 1; wq(Q/2); b[i] = sda_line; wq(Q/2); scl = 0;
        end
        wq(2); sda_m = nack; wq(Q); scl = 1; wq(Q); scl = 0; wq(2); sda_m = 1; wq(2);
    endtask

    task automatic open_at(input logic [7:0] dev, input logic [7:0] ptr, input string req);
        logic a;
        bus_start();
        send(dev, a);  chk({req, " dev ack"}, a, 1);
        send(ptr, a);  chk({req, " ptr ack"}, a, 1);
    endtask

    task automatic wr_data(input logic [7:0] b, input string req);
        logic a;
        send(b, a); chk({req, " data ack"}, a, 1);
    endtask

    task automatic read_at(input logic [7:0] dev, input logic [7:0] ptr, input int n,
                           output logic [7:0] o0, output logic [7:0] o1, input string req);
        logic a;
        open_at(dev, ptr, req);
        bus_rstart();
        send(dev | 8'h01, a); chk({req, " rd dev ack"}, a, 1);
        recv(n == 1, o0);
        o1 = 8'h00;
        if (n > 1) recv(1'b1, o1);
        bus_stop();
    endtask

    task automatic t_reset();
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 soft_disable", soft_dis, 0);
    endtask

    task automatic t_ident_read();
        logic [7:0] b0, b1, b2;
        logic a;
        open_at(8'hA0, 8'h10, "R2");
        bus_rstart();
        send(8'hA1, a); chk("R2 rd ack", a, 1);
        recv(0, b0); recv(0, b1); recv(1, b2);
        bus_stop();
        chk("R2 byte 0x10", b0, 8'h10 ^ SEED);
        chk("R2 byte 0x11", b1, 8'h11 ^ SEED);
        chk("R2 byte 0x12", b2, 8'h12 ^ SEED);
    endtask

    task automatic t_bad_addr();
        logic a;
        bus_start();
        send(8'hA4, a); chk("R3 no ack 0xA4", a, 0);
        send(8'hA2, a); chk("R3 stays silent", a, 0);
        bus_stop();
        bus_start();
        send(8'h30, a); chk("R3 no ack 0x30", a, 0);
        bus_stop();
    endtask

    task automatic t_diag_rw();
        logic [7:0] x, y;
        open_at(8'hA2, 8'h05, "R4");
        wr_data(8'h11, "R4"); wr_data(8'h22, "R4"); wr_data(8'h33, "R4");
        bus_stop();
        read_at(8'hA2, 8'h05, 2, x, y, "R4");
        chk("R4 byte 5", x, 8'h11);
        chk("R4 byte 6", y, 8'h22);
        read_at(8'hA2, 8'h07, 1, x, y, "R6");
        chk("R6 byte 7 lower half", x, 8'h33);
        open_at(8'hA2, 8'd128, "R6");
        wr_data(8'h44, "R6");
        bus_stop();
        open_at(8'hA2, 8'd247, "R6");
        wr_data(8'h55, "R6");
        bus_stop();
        read_at(8'hA2, 8'd128, 1, x, y, "R6");
        chk("R6 byte 128", x, 8'h44);
        read_at(8'hA2, 8'd247, 1, x, y, "R6");
        chk("R6 byte 247", x, 8'h55);
    endtask

    task automatic t_wrap();
        logic [7:0] x, y;
        open_at(8'hA2, 8'd247, "R5");
        wr_data(8'h66, "R5");
        bus_stop();
        open_at(8'hA2, 8'd255, "R5");
        wr_data(8'h77, "R5"); wr_data(8'h88, "R5");
        bus_stop();
        read_at(8'hA2, 8'd0, 1, x, y, "R5");
        chk("R5 write wrapped to 0", x, 8'h88);
        read_at(8'hA0, 8'd255, 2, x, y, "R5");
        chk("R5 read ident 255", x, 8'hFF ^ SEED);
        chk("R5 read wrapped ident 0", y, 8'h00 ^ SEED);
    endtask

    task automatic t_discard();
        logic [7:0] x, y;
        open_at(8'hA0, 8'd3, "R7");
        wr_data(8'hFF, "R7");
        bus_stop();
        read_at(8'hA0, 8'd3, 1, x, y, "R7");
        chk("R7 ident unchanged", x, 8'h03 ^ SEED);
        open_at(8'hA2, 8'd250, "R7");
        wr_data(8'h99, "R7");
        bus_stop();
        read_at(8'hA2, 8'd250, 1, x, y, "R7");
        chk("R7 byte 250 discarded", x, 8'h00);
    endtask

    task automatic t_live();
        logic [7:0] x, y;
        tx_dis = 1; rate = 1; fault = 0; los = 1; nrdy = 1;
        read_at(8'hA2, 8'd110, 1, x, y, "R8");
        chk("R8 live pattern A", x, 8'b1001_0011);
        tx_dis = 0; rate = 0; fault = 1; los = 0; nrdy = 0;
        read_at(8'hA2, 8'd110, 1, x, y, "R8");
        chk("R8 live pattern B", x, 8'b0000_0100);
    endtask

    task automatic t_soft();
        logic [7:0] x, y;
        open_at(8'hA2, 8'd110, "R9");
        wr_data(8'hFF, "R9");
        bus_stop();
        chk("R9 soft_disable set", soft_dis, 1);
        read_at(8'hA2, 8'd110, 1, x, y, "R9");
        chk("R9 byte 110 after 0xFF", x, 8'b0100_0100);
        open_at(8'hA2, 8'd110, "R9");
        wr_data(8'hBF, "R9");
        bus_stop();
        chk("R9 soft_disable cleared", soft_dis, 0);
        read_at(8'hA2, 8'd109, 1, x, y, "R9");
        chk("R9 byte 109 untouched", x, 8'h00);
    endtask

    task automatic t_stop_idle();
        logic a;
        open_at(8'hA2, 8'd20, "R10");
        bus_stop();
        chk("R10 released after stop", sda_oe, 0);
        send(8'hA2, a); chk("R10 no ack without start", a, 0);
        send(8'h00, a); chk("R10 still silent", a, 0);
    endtask

    task automatic t_nack_end();
        logic [7:0] b;
        logic a;
        open_at(8'hA0, 8'd0, "R11");
        bus_rstart();
        send(8'hA1, a); chk("R11 rd ack", a, 1);
        recv(1, b);
        chk("R11 byte", b, 8'h00 ^ SEED);
        sda_m = 1;
        for (int i = 0; i < 9; i++) begin
            wq(Q); scl = 1; wq(Q/2);
            chk("R11 no drive after nack", sda_oe, 0);
            wq(Q/2); scl = 0;
        end
        wq(Q); bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        wq(5); rst_n = 1; wq(5);
        t_reset();
        t_ident_read();
        t_bad_addr();
        t_diag_rw();
        t_wrap();
        t_discard();
        t_live();
        t_soft();
        t_stop_idle();
        t_nack_end();
        chk("R12 drive changed with SCL high", r12_bad, 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule